// File: doc/BRIEF.md
# Supply Reset and Power-Good Supervisor

This block turns per-regulator "in regulation" flags into two supervisory pins for a five-rail power manager. The reset pin follows the core rail (regulator A). The power-good pin follows either the collective group of rails A, C, D and E, or a single rail picked from C, D or E. Either pin goes to its fault state one cycle after a watched rail is lost. When the rail comes back, the pin stays in fault until a programmable hold time has been counted on a 1 ms tick.

One 8-bit control byte sets the behaviour of both pins: polarity, hold time and which rails are watched. The analog comparators are outside the block and arrive as flags. A write strobe that has already been address-decoded loads the control byte. Both pins can only drive while the digital-I/O rail (regulator B) is switched on. When it is off, both pins are held low.

Top module: `rail_supervisor`

## Requirements
- R1: While reset is active and afterwards, the control byte holds 0x06. This gives both hold codes a 100 ms hold, both polarity bits 0 and the collective group. Both pins start in the fault state.
- R2: Rail index 0 (A) drives the reset pin. The pin enters fault on the clock edge after flag A or enable A is seen low.
- R3: Reset hold code in control bits 1:0 selects the hold time: 00 gives 150 ms, 01 gives 50 ms, 10 gives 100 ms, 11 gives 0 ms. One 50 ms step is STEP_TICKS ticks.
- R4: Power-good hold code in control bits 3:2 selects the hold time: 00 gives 150 ms, 01 gives 100 ms, 10 gives 50 ms, 11 gives 0 ms.
- R5: Group select in control bits 5:4 picks the watched rails: 00 watches A, C, D and E together, 01 watches E (index 4), 10 watches C (index 2), 11 watches D (index 3). A rail outside the group has no effect on the power-good pin.
- R6: Control bit 6 sets the reset pin polarity and bit 7 sets the power-good pin polarity. With the bit at 0 the pin is high on fault and low when good. With the bit at 1 it is high when good and low on fault.
- R7: A pin leaves fault on the edge that samples the N-th tick after the watched rails are good, where N is the hold in ticks, counted as at least 1. A loss of a watched rail during the hold restarts the count.
- R8: A rail whose enable is low counts as out of regulation, even when its flag is high.
- R9: While enable B (index 1) is low, both pins are driven low. The internal state keeps running.
- R10: With a 0 ms code, the pin clears on the edge that samples the first tick after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (chip enable low) |
| msTick | input | 1 | One-cycle pulse every millisecond |
| regOk | input | 5 | Per-rail in-regulation flags, index 0 = A through 4 = E |
| regOn | input | 5 | Per-rail enable bits, same indexing |
| cfgWe | input | 1 | Control byte write strobe |
| cfgData | input | 8 | Control byte write data |
| resetOut | output | 1 | Reset pin |
| pwrGoodOut | output | 1 | Power-good pin |

## Verification
A wrong hold counter shows up at a pin as a clear edge that comes early or late by whole ticks. A wrong group decode or a missed restart shows up as a pin that clears while a watched rail is down, one edge after the mistake. A wrong polarity or gating state shows at the pin in the same cycle. The bench compares both pins with a behavioural model on every cycle, so any such fault is reported within one clock of its first visible effect.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int NUM_RAILS = 5;
  localparam int RAIL_A = 0;
  localparam int RAIL_B = 1;
  localparam int RAIL_C = 2;
  localparam int RAIL_D = 3;
  localparam int RAIL_E = 4;
  localparam logic [7:0] CFG_RESET = 8'h06;

  typedef struct packed {
    logic       tick;
    logic       rstGood;
    logic       pgGood;
    logic [1:0] rstSteps;
    logic [1:0] pgSteps;
    logic       rstPol;
    logic       pgPol;
  } supvStrobes_t;

  function automatic logic [1:0] rstCodeSteps(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd3;
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] pgCodeSteps(input logic [1:0] code);
    return ~code;
  endfunction
endpackage

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msTick,
  input  logic [NUM_RAILS-1:0] regOk,
  input  logic [NUM_RAILS-1:0] regOn,
  input  logic                 cfgWe,
  input  logic [7:0]           cfgData,
  output logic [7:0]           cfg,
  output supvStrobes_t         strb
);
  logic [NUM_RAILS-1:0] railGood;
  logic                 groupGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfg <= CFG_RESET;
    else if (cfgWe) cfg <= cfgData;
  end

  assign railGood = regOk & regOn;

  always_comb begin
    case (cfg[5:4])
      2'b00:   groupGood = railGood[RAIL_A] & railGood[RAIL_C] &
                           railGood[RAIL_D] & railGood[RAIL_E];
      2'b01:   groupGood = railGood[RAIL_E];
      2'b10:   groupGood = railGood[RAIL_C];
      default: groupGood = railGood[RAIL_D];
    endcase
  end

  always_comb begin
    strb.tick     = msTick;
    strb.rstGood  = railGood[RAIL_A];
    strb.pgGood   = groupGood;
    strb.rstSteps = rstCodeSteps(cfg[1:0]);
    strb.pgSteps  = pgCodeSteps(cfg[3:2]);
    strb.rstPol   = cfg[6];
    strb.pgPol    = cfg[7];
  end
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int STEP_TICKS = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  supvStrobes_t strb,
  input  logic         ioSupplyOn,
  output logic [1:0]   faultQ,
  output logic         resetOut,
  output logic         pwrGoodOut
);
  localparam int MAX_TICKS = 3 * STEP_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1) + 1;

  logic [1:0] goodV;
  logic [1:0] polV;
  logic [1:0] stepsV [2];
  logic [1:0] pinV;

  assign goodV     = {strb.pgGood, strb.rstGood};
  assign polV      = {strb.pgPol, strb.rstPol};
  assign stepsV[0] = strb.rstSteps;
  assign stepsV[1] = strb.pgSteps;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;
    logic [CW-1:0] cntInc;

    assign target = CW'(stepsV[ch]) * CW'(STEP_TICKS);
    assign cntInc = cnt + CW'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        faultQ[ch] <= 1'b1;
        cnt        <= '0;
      end else if (!goodV[ch]) begin
        faultQ[ch] <= 1'b1;
        cnt        <= '0;
      end else if (faultQ[ch] && strb.tick) begin
        if (cntInc >= target) faultQ[ch] <= 1'b0;
        else                  cnt        <= cntInc;
      end
    end

    assign pinV[ch] = ioSupplyOn & (faultQ[ch] ^ polV[ch]);
  end

  assign resetOut   = pinV[0];
  assign pwrGoodOut = pinV[1];
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import supv_pkg::*;
#(
  parameter int STEP_TICKS = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic [4:0] regOk,
  input  logic [4:0] regOn,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  output logic       resetOut,
  output logic       pwrGoodOut
);
  supvStrobes_t strb;
  logic [7:0]   cfg;
  logic [1:0]   faultQ;

  supv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .regOk(regOk), .regOn(regOn),
    .cfgWe(cfgWe), .cfgData(cfgData), .cfg(cfg), .strb(strb)
  );

  supv_datapath #(.STEP_TICKS(STEP_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioSupplyOn(regOn[RAIL_B]),
    .faultQ(faultQ), .resetOut(resetOut), .pwrGoodOut(pwrGoodOut)
  );
endmodule

// File: rtl/rail_supervisor_chk.sv
module rail_supervisor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       msTick,
  input logic [4:0] regOk,
  input logic [4:0] regOn,
  input logic [7:0] cfg,
  input logic [1:0] faultQ,
  input logic       resetOut,
  input logic       pwrGoodOut
);
  logic aGood;
  assign aGood = regOk[0] & regOn[0];

  p_rst_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    !aGood |=> faultQ[0]);

  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regOn[1] |-> (!resetOut && !pwrGoodOut));

  p_rst_pol_r6: assert property (@(posedge clk) disable iff (!rstN)
    regOn[1] |-> (resetOut == (faultQ[0] ^ cfg[6])));

  p_pg_pol_r6: assert property (@(posedge clk) disable iff (!rstN)
    regOn[1] |-> (pwrGoodOut == (faultQ[1] ^ cfg[7])));

  p_rst_clear_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultQ[0]) |-> ($past(msTick) && $past(aGood)));

  p_pg_clear_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultQ[1]) |-> $past(msTick));
endmodule

bind rail_supervisor rail_supervisor_chk u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .regOk(regOk), .regOn(regOn),
  .cfg(cfg), .faultQ(faultQ), .resetOut(resetOut), .pwrGoodOut(pwrGoodOut)
);

// File: tb/rail_supervisor_tb.sv
module rail_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;
  localparam int TICK_DIV = 3;

  logic clk = 0, rstN = 0, msTick = 0, cfgWe = 0;
  logic [4:0] regOk = 5'h1f, regOn = 5'h1f;
  logic [7:0] cfgData = 0;
  logic resetOut, pwrGoodOut;

  int checks = 0, errors = 0, cycles = 0, tickDiv = 0;
  string curReq = "R1";

  // behavioural model state
  logic [7:0] mCfg = 8'h06;
  bit mFault [2] = '{1, 1};
  int mCnt [2] = '{0, 0};

  rail_supervisor #(.STEP_TICKS(STEP)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .regOk(regOk), .regOn(regOn),
    .cfgWe(cfgWe), .cfgData(cfgData), .resetOut(resetOut), .pwrGoodOut(pwrGoodOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int holdTicks(input int ch, input logic [1:0] code);
    int ms;
    if (ch == 0) ms = (code == 0) ? 150 : (code == 1) ? 50 : (code == 2) ? 100 : 0;
    else         ms = (code == 0) ? 150 : (code == 1) ? 100 : (code == 2) ? 50 : 0;
    return (ms / 50) * STEP;
  endfunction

  function automatic bit railUp(input int i);
    return regOk[i] && regOn[i];
  endfunction

  function automatic bit groupUp(input logic [1:0] sel);
    if (sel == 1) return railUp(4);
    if (sel == 2) return railUp(2);
    if (sel == 3) return railUp(3);
    return railUp(0) && railUp(2) && railUp(3) && railUp(4);
  endfunction

  // tick driver
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % TICK_DIV;
    msTick <= (tickDiv == 0);
  end

  // model update at the edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 8'h06; mFault = '{1, 1}; mCnt = '{0, 0};
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        bit up;
        int need;
        up = (ch == 0) ? railUp(0) : groupUp(mCfg[5:4]);
        need = holdTicks(ch, (ch == 0) ? mCfg[1:0] : mCfg[3:2]);
        if (!up) begin
          mFault[ch] = 1; mCnt[ch] = 0;
        end else if (mFault[ch] && msTick) begin
          if (mCnt[ch] + 1 >= need) mFault[ch] = 0;
          else mCnt[ch] = mCnt[ch] + 1;
        end
      end
      if (cfgWe) mCfg = cfgData;
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    cycles++;
    #(CLK_PERIOD/4);
    if (rstN) begin
      bit eR, eP;
      eR = regOn[1] && (mFault[0] ^ mCfg[6]);
      eP = regOn[1] && (mFault[1] ^ mCfg[7]);
      checks += 2;
      if (resetOut !== eR) begin
        errors++;
        $display("FAIL %s resetOut actual %b expected %b at cycle %0d", curReq, resetOut, eR, cycles);
      end
      if (pwrGoodOut !== eP) begin
        errors++;
        $display("FAIL %s pwrGoodOut actual %b expected %b at cycle %0d", curReq, pwrGoodOut, eP, cycles);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinCheck(input string req, input logic expR, input logic expP);
    @(posedge clk); #(CLK_PERIOD/4);
    checks++;
    if (resetOut !== expR || pwrGoodOut !== expP) begin
      errors++;
      $display("FAIL %s pins actual %b%b expected %b%b", req, resetOut, pwrGoodOut, expR, expP);
    end
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWe = 1; cfgData = v;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic dropRecover(input int rail, input int lowCyc, input int waitAfter);
    @(negedge clk); regOk[rail] = 0;
    waitCyc(lowCyc);
    regOk[rail] = 1;
    waitCyc(waitAfter);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    pinCheck("R1", 1'b1, 1'b1);       // fault state under reset, polarity 0
    rstN = 1;
    pinCheck("R1", 1'b1, 1'b1);
    waitCyc(40);
    pinCheck("R1", 1'b0, 1'b0);       // 100 ms hold = 8 ticks = 24 cycles, done

    curReq = "R2";
    @(negedge clk); regOk[0] = 0;
    pinCheck("R2", 1'b1, 1'b1);
    regOk[0] = 1; waitCyc(40);

    curReq = "R3";
    for (int c = 0; c < 4; c++) begin
      writeCfg(8'h0c | 8'(c));        // pg code 11, reset code c
      dropRecover(0, 2, 50);
      pinCheck("R3", 1'b0, 1'b0);
    end

    curReq = "R4";
    for (int c = 0; c < 4; c++) begin
      writeCfg(8'h03 | 8'(c << 2));
      dropRecover(2, 2, 50);
      pinCheck("R4", 1'b0, 1'b0);
    end

    curReq = "R5";
    writeCfg(8'h1f);                  // watch E only, zero holds
    @(negedge clk); regOk[2] = 0;
    pinCheck("R5", 1'b0, 1'b0);       // C outside group: no effect
    regOk[2] = 1;
    @(negedge clk); regOk[4] = 0;
    pinCheck("R5", 1'b0, 1'b1);
    regOk[4] = 1; waitCyc(10);
    writeCfg(8'h2f); dropRecover(2, 3, 10);
    writeCfg(8'h3f); dropRecover(3, 3, 10);
    writeCfg(8'h0f); dropRecover(4, 3, 10);
    pinCheck("R5", 1'b0, 1'b0);

    curReq = "R6";
    writeCfg(8'hcf);
    pinCheck("R6", 1'b1, 1'b1);       // good shows high
    @(negedge clk); regOk[0] = 0; regOk[3] = 0;
    pinCheck("R6", 1'b0, 1'b0);
    regOk[0] = 1; regOk[3] = 1; waitCyc(10);

    curReq = "R7";
    writeCfg(8'h00);                  // 150 ms holds
    dropRecover(0, 2, 20);
    regOk[0] = 0; regOk[2] = 0;       // drop mid-hold
    waitCyc(2);
    regOk[0] = 1; regOk[2] = 1;
    waitCyc(30);
    pinCheck("R7", 1'b1, 1'b1);       // restarted count not yet done
    waitCyc(20);
    pinCheck("R7", 1'b0, 1'b0);

    curReq = "R8";
    writeCfg(8'h3f);                  // watch D
    @(negedge clk); regOn[3] = 0;
    pinCheck("R8", 1'b0, 1'b1);
    regOn[3] = 1; waitCyc(10);

    curReq = "R9";
    @(negedge clk); regOn[1] = 0; regOk[0] = 0;
    pinCheck("R9", 1'b0, 1'b0);
    regOk[0] = 1; waitCyc(10);
    regOn[1] = 1;
    pinCheck("R9", 1'b0, 1'b0);

    curReq = "R10";
    writeCfg(8'h0f);
    dropRecover(0, 2, 0);
    waitCyc(TICK_DIV + 2);
    pinCheck("R10", 1'b0, 1'b0);

    waitCyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule